// File: doc/BRIEF.md
# Burst-Capable Dual PWM Generator

This block drives two independent pulse outputs. Each channel stores a high-phase length, a low-phase length and a pulse count, all counted in 100 us timebase units. A shared run mask starts and stops the channels. Every setting is written through a simple command port that carries a valid strobe, an 8-bit command code and a 16-bit parameter. The code selects the channel and the field. A query command reads any stored setting, or the run mask, back through a registered response port.

When a channel's run bit is set, it emits pulses that each begin with the high phase. With a non-zero pulse count, the channel stops after that many pulses: the output falls low and the channel's run bit clears by itself. With a pulse count of zero, the channel keeps running until software clears the bit. A stopped channel holds its output low and reloads its counters from the stored settings. The intended use is to stop a channel, change its lengths or pulse count, then set its run bit again.

Top module: `pwm_burst_gen`

## Requirements
- R1: After reset every output is low, no response is pending, the run mask is 0 and every stored length and pulse count reads back as 0.
- R2: Command code 0x10+2n writes the high length of channel n. Code 0x11+2n writes its low length. Code 0x14+n writes its pulse count. Each field is the full 16-bit parameter.
- R3: Command code 0x1F loads the run mask from parameter bit n for channel n. A channel whose bit is clear drives its output low from the cycle after the write.
- R4: In the cycle after the run bit is set, the output goes high. It stays high for high-length × P clock cycles and then stays low for low-length × P cycles, where P = CLK_HZ / TICK_HZ.
- R5: A stored length of 0 behaves as a length of 1.
- R6: With a pulse count N > 0, exactly N pulses are emitted. After the last low phase the output stays low and the channel's run bit reads back as 0.
- R7: With a pulse count of 0, the channel repeats pulses for as long as its run bit stays set.
- R8: A run-mask write that lands in the same cycle as a burst's completion takes precedence. If the write keeps the bit set, a fresh burst starts high in the next cycle.
- R9: Codes outside the defined set change no state. A query (code 0x03, parameter low byte = target code) of an undefined target returns 0.
- R10: Each command produces a response in the next cycle. The response carries the command code. Its data is the queried value for code 0x03 and 0 for any other code.
- R11: The two channels time their pulses independently when both run at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_code_i | input | 8 | Command code |
| cmd_param_i | input | 16 | Command parameter |
| rsp_valid_o | output | 1 | Response strobe, one cycle after a command |
| rsp_code_o | output | 8 | Echo of the command code |
| rsp_data_o | output | 16 | Query result, or 0 |
| pwm_o | output | NUM_CH | Pulse outputs, bit n for channel n |

## Verification
A channel's own burst completion and a software run-mask write can both update the same run bit in one cycle. The bench starts a one-pulse burst and counts cycles so that a run-mask write keeping the bit set is strobed into the exact edge where the final low phase ends. The bench then requires the output to be high in the following cycle. It requires the whole next pulse train to match a freshly started burst. Last, it requires a query to show the bit cleared once that second burst has finished.

// File: rtl/pwm_burst_pkg.sv
// Package: shared widths and command-code helpers for the burst PWM block.
// Assumes at most two channels, so that the field codes do not overlap.
package pwm_burst_pkg;

    localparam int DATA_W = 16;
    localparam int CODE_W = 8;

    localparam logic [CODE_W-1:0] CODE_QUERY    = 8'h03;
    localparam logic [CODE_W-1:0] CODE_RUN_MASK = 8'h1F;

    // Code that writes the high length of channel n
    function automatic logic [CODE_W-1:0] hi_code(input int n);
        return CODE_W'(8'h10 + 2 * n);
    endfunction

    // Code that writes the low length of channel n
    function automatic logic [CODE_W-1:0] lo_code(input int n);
        return CODE_W'(8'h11 + 2 * n);
    endfunction

    // Code that writes the pulse count of channel n
    function automatic logic [CODE_W-1:0] cnt_code(input int n);
        return CODE_W'(8'h14 + n);
    endfunction

    // A stored length of zero counts as one unit
    function automatic logic [DATA_W-1:0] eff_len(input logic [DATA_W-1:0] v);
        return (v == '0) ? DATA_W'(1) : v;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
// Module: divides the system clock down to the timebase tick.
// Emits a one-cycle tick every PRESCALE cycles while run_i is high.
// Restarts from zero whenever run_i is low, so that phase lengths are exact.
module pwm_prescaler #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);

    generate
        if (PRESCALE <= 1) begin : g_direct
            // Every running cycle is a tick
            assign tick_o = run_i;
        end else begin : g_count
            localparam int CW = $clog2(PRESCALE);
            localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
            logic [CW-1:0] div_q;

            // Divider count: cleared while idle, wraps at LAST
            always_ff @(posedge clk) begin
                if (!rst_n || !run_i) begin
                    div_q <= '0;
                end else if (div_q == LAST) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + CW'(1);
                end
            end

            assign tick_o = run_i && (div_q == LAST);

            // R4
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o)
                else $error("tick_spacing_chk: back-to-back ticks");
        end
    endgenerate

endmodule

// File: rtl/pwm_channel.sv
// Module: one pulse channel with a high phase, a low phase and an optional pulse count.
// Assumes that settings change only while run_i is low. While idle it reloads
// from the settings, and it pulses done_o in the cycle its final low phase ends.
module pwm_channel
    import pwm_burst_pkg::*;
#(
    parameter int PRESCALE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [DATA_W-1:0] hi_len_i,
    input  logic [DATA_W-1:0] lo_len_i,
    input  logic [DATA_W-1:0] count_i,
    output logic              pwm_o,
    output logic              done_o
);

    logic              tick;
    logic              phase_hi_q;
    logic [DATA_W-1:0] left_q;
    logic [DATA_W-1:0] pulses_q;
    logic              phase_end;
    logic              finite;

    pwm_prescaler #(.PRESCALE(PRESCALE)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_i),
        .tick_o (tick)
    );

    assign phase_end = run_i && tick && (left_q == DATA_W'(1));
    assign finite    = (count_i != '0);
    assign done_o    = phase_end && !phase_hi_q && finite && (pulses_q == DATA_W'(1));
    assign pwm_o     = run_i && phase_hi_q;

    // Phase and pulse bookkeeping: reload when idle or finished, else count ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_hi_q <= 1'b1;
            left_q     <= DATA_W'(1);
            pulses_q   <= '0;
        end else if (!run_i || done_o) begin
            phase_hi_q <= 1'b1;
            left_q     <= eff_len(hi_len_i);
            pulses_q   <= count_i;
        end else if (phase_end) begin
            if (phase_hi_q) begin
                phase_hi_q <= 1'b0;
                left_q     <= eff_len(lo_len_i);
            end else begin
                phase_hi_q <= 1'b1;
                left_q     <= eff_len(hi_len_i);
                if (finite) begin
                    pulses_q <= pulses_q - DATA_W'(1);
                end
            end
        end else if (tick) begin
            left_q <= left_q - DATA_W'(1);
        end
    end

    // R5
    nonzero_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (left_q != '0))
        else $error("nonzero_left_chk: phase counter reached zero");

    // R4
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick) |=> (!run_i || $stable(phase_hi_q)))
        else $error("phase_hold_chk: phase changed without a tick");

    // R6
    reload_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (phase_hi_q && pulses_q == $past(count_i)))
        else $error("reload_after_done_chk: no reload after burst end");

endmodule

// File: rtl/pwm_cmd_decode.sv
// Module: turns a command code into one-hot write strobes.
// Assumes NUM_CH <= 2. An unknown code raises no strobe.
module pwm_cmd_decode
    import pwm_burst_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              valid_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [NUM_CH-1:0] wr_hi_o,
    output logic [NUM_CH-1:0] wr_lo_o,
    output logic [NUM_CH-1:0] wr_cnt_o,
    output logic              wr_mask_o,
    output logic              query_o
);

    genvar n;
    generate
        for (n = 0; n < NUM_CH; n++) begin : g_ch
            assign wr_hi_o[n]  = valid_i && (code_i == hi_code(n));
            assign wr_lo_o[n]  = valid_i && (code_i == lo_code(n));
            assign wr_cnt_o[n] = valid_i && (code_i == cnt_code(n));
        end
    endgenerate

    assign wr_mask_o = valid_i && (code_i == CODE_RUN_MASK);
    assign query_o   = valid_i && (code_i == CODE_QUERY);

endmodule

// File: rtl/pwm_burst_gen.sv
// Module: top of the burst PWM block. Holds per-channel settings and the run mask,
// decodes commands, answers queries and instantiates one pulse channel per bit.
// Assumes CLK_HZ is a multiple of TICK_HZ. A mask write beats a burst completion.
module pwm_burst_gen
    import pwm_burst_pkg::*;
#(
    parameter int NUM_CH  = 2,
    parameter int CLK_HZ  = 100_000_000,
    parameter int TICK_HZ = 10_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [7:0]        cmd_code_i,
    input  logic [15:0]       cmd_param_i,
    output logic              rsp_valid_o,
    output logic [7:0]        rsp_code_o,
    output logic [15:0]       rsp_data_o,
    output logic [NUM_CH-1:0] pwm_o
);

    localparam int PRESCALE = CLK_HZ / TICK_HZ;

    logic [NUM_CH-1:0]             wr_hi, wr_lo, wr_cnt, done;
    logic                          wr_mask, query;
    logic [NUM_CH-1:0][DATA_W-1:0] hi_q, lo_q, cnt_q;
    logic [NUM_CH-1:0]             mask_q;
    logic [DATA_W-1:0]             rb_data;

    pwm_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
        .valid_i   (cmd_valid_i),
        .code_i    (cmd_code_i),
        .wr_hi_o   (wr_hi),
        .wr_lo_o   (wr_lo),
        .wr_cnt_o  (wr_cnt),
        .wr_mask_o (wr_mask),
        .query_o   (query)
    );

    // Settings storage: each field loads the parameter on its own strobe
    always_ff @(posedge clk) begin
        for (int n = 0; n < NUM_CH; n++) begin
            if (!rst_n) begin
                hi_q[n]  <= '0;
                lo_q[n]  <= '0;
                cnt_q[n] <= '0;
            end else begin
                if (wr_hi[n])  hi_q[n]  <= cmd_param_i;
                if (wr_lo[n])  lo_q[n]  <= cmd_param_i;
                if (wr_cnt[n]) cnt_q[n] <= cmd_param_i;
            end
        end
    end

    // Run mask: a software write wins, otherwise finished channels drop their bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_mask) begin
            mask_q <= cmd_param_i[NUM_CH-1:0];
        end else begin
            mask_q <= mask_q & ~done;
        end
    end

    // Query mux: select the stored field named by the parameter's low byte
    always_comb begin
        rb_data = '0;
        if (cmd_param_i[7:0] == CODE_RUN_MASK) begin
            rb_data[NUM_CH-1:0] = mask_q;
        end
        for (int n = 0; n < NUM_CH; n++) begin
            if (cmd_param_i[7:0] == hi_code(n))  rb_data = hi_q[n];
            if (cmd_param_i[7:0] == lo_code(n))  rb_data = lo_q[n];
            if (cmd_param_i[7:0] == cnt_code(n)) rb_data = cnt_q[n];
        end
    end

    // Response register: one response per command, data only for queries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            rsp_code_o  <= '0;
            rsp_data_o  <= '0;
        end else begin
            rsp_valid_o <= cmd_valid_i;
            rsp_code_o  <= cmd_valid_i ? cmd_code_i : 8'h00;
            rsp_data_o  <= query ? rb_data : '0;
        end
    end

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_chan
            pwm_channel #(.PRESCALE(PRESCALE)) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .run_i    (mask_q[c]),
                .hi_len_i (hi_q[c]),
                .lo_len_i (lo_q[c]),
                .count_i  (cnt_q[c]),
                .pwm_o    (pwm_o[c]),
                .done_o   (done[c])
            );

            // R6
            done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (done[c] && !wr_mask) |=> !mask_q[c])
                else $error("done_clears_chk: run bit survived burst end");

            // R3
            stopped_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_mask && !cmd_param_i[c]) |=> !pwm_o[c])
                else $error("stopped_low_chk: output high after stop");
        end
    endgenerate

    // R10
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_i |=> (rsp_valid_o && rsp_code_o == $past(cmd_code_i)))
        else $error("rsp_follows_chk: missing response");

    // R10
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid_i |=> !rsp_valid_o)
        else $error("rsp_quiet_chk: response without command");

endmodule

// File: tb/pwm_burst_gen_bench.sv
// Directed bench for the burst PWM block. Each task runs one scenario and checks it.
module pwm_burst_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 2;
    localparam int CLK_HZ     = 40_000;
    localparam int TICK_HZ    = 10_000;
    localparam int P          = CLK_HZ / TICK_HZ;
    localparam int CAP_MAX    = 256;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [7:0]        cmd_code = '0;
    logic [15:0]       cmd_param = '0;
    logic              rsp_valid;
    logic [7:0]        rsp_code;
    logic [15:0]       rsp_data;
    logic [NUM_CH-1:0] pwm;

    int tests = 0;
    int fails = 0;
    bit done_flag = 0;

    logic cap0 [CAP_MAX];
    logic cap1 [CAP_MAX];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_burst_gen #(.NUM_CH(NUM_CH), .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_pwm_burst_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid),
        .cmd_code_i  (cmd_code),
        .cmd_param_i (cmd_param),
        .rsp_valid_o (rsp_valid),
        .rsp_code_o  (rsp_code),
        .rsp_data_o  (rsp_data),
        .pwm_o       (pwm)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // Drive one command; returns at the falling edge after the capture edge
    task automatic send(input logic [7:0] code, input logic [15:0] param);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = code;
        cmd_param = param;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_code  = '0;
        cmd_param = '0;
    endtask

    // Query a stored field and compare the response
    task automatic query(input logic [7:0] target, input int exp, input string req);
        send(8'h03, {8'h00, target});
        chk(rsp_valid && rsp_code == 8'h03 && int'(rsp_data) == exp, req, int'(rsp_data), exp);
    endtask

    task automatic cfg(input int ch, input int h, input int l, input int b);
        send(8'(8'h10 + 2*ch), 16'(h));
        send(8'(8'h11 + 2*ch), 16'(l));
        send(8'(8'h14 + ch), 16'(b));
    endtask

    // Expected output k cycles after the run bit rose
    function automatic logic model(input int h, input int l, input int b, input int k);
        int eh = (h == 0) ? 1 : h;
        int el = (l == 0) ? 1 : l;
        int per = (eh + el) * P;
        if (b != 0 && (k / per) >= b) return 1'b0;
        return (k % per) < eh * P;
    endfunction

    // Sample both outputs at falling edges, starting now
    task automatic capture(input int n);
        for (int i = 0; i < n; i++) begin
            cap0[i] = pwm[0];
            cap1[i] = pwm[1];
            @(negedge clk);
        end
    endtask

    task automatic check_wave(input int ch, input int h, input int l, input int b,
                              input int n, input string req);
        int bad = -1;
        logic a;
        for (int i = 0; i < n; i++) begin
            a = (ch == 0) ? cap0[i] : cap1[i];
            if (bad < 0 && a !== model(h, l, b, i)) bad = i;
        end
        if (bad >= 0) begin
            a = (ch == 0) ? cap0[bad] : cap1[bad];
            chk(1'b0, req, int'(a), int'(model(h, l, b, bad)));
            $display("  mismatch at cycle %0d of channel %0d", bad, ch);
        end else begin
            chk(1'b1, req, 0, 0);
        end
    endtask

    task automatic t_reset;
        chk(pwm == '0, "R1 outputs low", int'(pwm), 0);
        chk(rsp_valid == 1'b0, "R1 no response", int'(rsp_valid), 0);
        query(8'h1F, 0, "R1 mask zero");
        query(8'h10, 0, "R1 high length zero");
        query(8'h15, 0, "R1 count zero");
    endtask

    task automatic t_config;
        cfg(0, 3, 5, 2);
        cfg(1, 7, 1, 16'hFFFF);
        chk(rsp_valid && rsp_code == 8'h15 && rsp_data == 16'h0, "R10 write echo",
            int'(rsp_code), 8'h15);
        query(8'h10, 3, "R2 ch0 high");
        query(8'h11, 5, "R2 ch0 low");
        query(8'h14, 2, "R2 ch0 count");
        query(8'h12, 7, "R2 ch1 high");
        query(8'h13, 1, "R2 ch1 low");
        query(8'h15, 16'hFFFF, "R2 ch1 count");
    endtask

    task automatic t_burst;
        cfg(0, 2, 3, 3);
        send(8'h1F, 16'h0001);
        capture(80);
        check_wave(0, 2, 3, 3, 80, "R4 R6 three-pulse burst");
        query(8'h1F, 0, "R6 run bit cleared");
    endtask

    task automatic t_zero_len;
        cfg(0, 0, 0, 2);
        send(8'h1F, 16'h0001);
        capture(30);
        check_wave(0, 0, 0, 2, 30, "R5 zero lengths");
    endtask

    task automatic t_continuous;
        cfg(1, 1, 2, 0);
        send(8'h1F, 16'h0002);
        capture(120);
        check_wave(1, 1, 2, 0, 120, "R7 continuous");
        query(8'h1F, 2, "R7 run bit kept");
        send(8'h1F, 16'h0000);
        chk(pwm[1] == 1'b0, "R3 stop drives low", int'(pwm[1]), 0);
        repeat (20) @(negedge clk);
        chk(pwm == '0, "R3 stays low", int'(pwm), 0);
    endtask

    task automatic t_stop_mid_high;
        cfg(0, 5, 5, 0);
        send(8'h1F, 16'h0001);
        repeat (3) @(negedge clk);
        chk(pwm[0] == 1'b1, "R3 high before stop", int'(pwm[0]), 1);
        send(8'h1F, 16'h0000);
        chk(pwm[0] == 1'b0, "R3 stop mid high", int'(pwm[0]), 0);
    endtask

    task automatic t_indep;
        cfg(0, 1, 3, 4);
        cfg(1, 2, 1, 0);
        send(8'h1F, 16'h0003);
        capture(100);
        check_wave(0, 1, 3, 4, 100, "R11 channel 0");
        check_wave(1, 2, 1, 0, 100, "R11 channel 1");
        query(8'h1F, 2, "R11 only channel 0 stopped");
        send(8'h1F, 16'h0000);
    endtask

    task automatic t_coincide;
        cfg(0, 1, 1, 1);
        send(8'h1F, 16'h0001);
        // Burst ends at the 8th edge after enable; strobe the write into that edge
        repeat (6) @(negedge clk);
        send(8'h1F, 16'h0001);
        chk(pwm[0] == 1'b1, "R8 write wins, restart high", int'(pwm[0]), 1);
        capture(16);
        check_wave(0, 1, 1, 1, 16, "R8 fresh burst");
        query(8'h1F, 0, "R8 second burst clears bit");
    endtask

    task automatic t_unknown;
        cfg(0, 9, 4, 6);
        send(8'h18, 16'hBEEF);
        chk(rsp_valid && rsp_code == 8'h18 && rsp_data == 16'h0, "R9 unknown code response",
            int'(rsp_data), 0);
        send(8'h1E, 16'hFFFF);
        chk(pwm == '0, "R9 unknown code no start", int'(pwm), 0);
        query(8'h10, 9, "R9 high untouched");
        query(8'h11, 4, "R9 low untouched");
        query(8'h14, 6, "R9 count untouched");
        query(8'h1F, 0, "R9 mask untouched");
        query(8'h50, 0, "R9 undefined target reads 0");
    endtask

    task automatic finish_run;
        if (!done_flag) begin
            done_flag = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_config;
        t_burst;
        t_zero_len;
        t_continuous;
        t_stop_mid_high;
        t_indep;
        t_coincide;
        t_unknown;
        finish_run;
    end

    initial begin
        repeat (100_000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end

endmodule